// File: doc/BRIEF.md
# Clock divider and distribution stage

This block is the digital back end of a phase-locked clock driver. The loop's oscillator arrives as an input clock, and the loop's raw lock flag arrives as an input. One of two reference clocks is chosen. The chosen reference goes back out to the phase detector. The block then picks its source clock: the oscillator in normal locked operation, or the chosen reference in test-bypass mode.

The source clock passes through a divider that divides by one or by two. From that divider the block produces a double-rate clock, a bank of in-phase main clocks, one inverted main clock and a half-rate clock. Each clock output is a data bit with its own output-enable bit, so the pad ring can build a three-state driver from them.

A single active-low input does two jobs at once. It floats every clock output, and it clears the divider. When it is released, the outputs come back in a defined low state. They stay there until the source clock delivers its first few rising edges. The lock output reports the loop's lock flag only while the oscillator is in use.

Top module: `clkdist_top`

## Requirements
- R1: `pd_ref_o` equals `ref1_clk_i` when `ref_sel_i` is 1, and equals `ref0_clk_i` when `ref_sel_i` is 0. The reference that is not selected has no effect on any output.
- R2: When `pll_en_i` is 1, the source clock is `vco_clk_i`. When `pll_en_i` is 0, the source clock is the selected reference, and `vco_clk_i` has no effect on the clock outputs.
- R3: With `div1_i` = 0 (divide by two), let c be the count of divider advances modulo 8. The outputs follow c as: `dbl_o` = c bit 0, every `q_o` bit = c bit 1, `half_o` = c bit 2.
- R4: With `div1_i` = 1 (divide by one), `dbl_o` is the inverse of the source clock, every `q_o` bit = c bit 0, and `half_o` = c bit 1.
- R5: All `q_o` bits are equal. `inv_o` is the inverse of `q_o` once `q_o` has been high since reset. Until then, `inv_o` is 0.
- R6: While `rst_ni` is 0, every output-enable is 0 and every clock data output is 0. This takes effect at once, with no clock edge needed, and it clears the divider.
- R7: Once `rst_ni` is 1, every output-enable is 1. `q_o`, `inv_o` and `half_o` are 0, and `dbl_o` is 0 in divide-by-two mode or the inverse of the source clock in divide-by-one mode. The divider first advances on rising edge number SYNC_STAGES+1 of the source clock (the third edge by default). Until then the outputs hold these levels.
- R8: `lock_o` is 0 whenever `pll_en_i` is 0. Otherwise it equals `loop_lock_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low output disable and divider reset |
| vco_clk_i | input | 1 | Oscillator clock from the loop |
| ref0_clk_i | input | 1 | Reference clock 0 |
| ref1_clk_i | input | 1 | Reference clock 1 |
| ref_sel_i | input | 1 | Reference select (1 picks reference 1) |
| pll_en_i | input | 1 | 1: oscillator is source; 0: reference bypass |
| div1_i | input | 1 | 1: divide by one; 0: divide by two |
| loop_lock_i | input | 1 | Raw lock flag from the loop |
| pd_ref_o | output | 1 | Selected reference to the phase detector |
| dbl_o | output | 1 | Double-rate clock data |
| dbl_oe_o | output | 1 | Double-rate clock enable |
| q_o | output | NUM_Q | In-phase main clocks data |
| q_oe_o | output | NUM_Q | In-phase main clocks enables |
| inv_o | output | 1 | Inverted main clock data |
| inv_oe_o | output | 1 | Inverted main clock enable |
| half_o | output | 1 | Half-rate clock data |
| half_oe_o | output | 1 | Half-rate clock enable |
| lock_o | output | 1 | Gated lock status |

## Verification
The reference select, the lock gating, the output enables and the reset clearing have no register on their path. The bench therefore checks them one time unit after it changes the input.

Each divider output changes just after the source rising edge that advances the count. The count first advances on edge SYNC_STAGES+1 after release. The bench numbers every source edge it produces and derives the expected count from that edge number. It samples once in the high phase of the source and once in the low phase, both clear of the edges, so the divide-by-one double-rate output is seen at both of its levels.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;
  localparam int unsigned CNT_W = 3;  // double, main and half rate bits

  typedef struct packed {
    logic dbl;
    logic q;
    logic inv;
    logic half;
  } div_bits_t;
endpackage

// File: rtl/clkdist_src_sel.sv
module clkdist_src_sel (
  input  logic ref0_clk_i,
  input  logic ref1_clk_i,
  input  logic ref_sel_i,
  input  logic vco_clk_i,
  input  logic pll_en_i,
  output logic ref_clk_o,
  output logic src_clk_o
);
  always_comb begin
    ref_clk_o = ref_sel_i ? ref1_clk_i : ref0_clk_i;
    src_clk_o = pll_en_i ? vco_clk_i : ref_clk_o;
  end
endmodule

// File: rtl/clkdist_rst_sync.sv
module clkdist_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic run_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= 1'b0;
        else         run_q <= 1'b1;
      end
      assign run_o = run_q;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
      assign run_o = sync_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/clkdist_div.sv
module clkdist_div
  import clkdist_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      div1_i,
  output div_bits_t bits_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             armed_q;  // one edge since reset, used by checks only
  logic             dbl_bit, q_bit, half_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  // pick the tap that feeds each output
  always_comb begin
    if (div1_i) begin
      dbl_bit  = 1'b0;
      q_bit    = cnt_q[0];
      half_bit = cnt_q[1];
    end else begin
      dbl_bit  = cnt_q[0];
      q_bit    = cnt_q[1];
      half_bit = cnt_q[2];
    end
  end

  // the inverted output stays low until the main output has risen once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      seen_q  <= seen_q | q_bit;
      armed_q <= 1'b1;
    end
  end

  assign bits_o = '{dbl: dbl_bit, q: q_bit, inv: seen_q & ~q_bit, half: half_bit};

  p_dbl_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !div1_i && $past(run_i)) |-> (bits_o.dbl != $past(bits_o.dbl)))
    else $error("double-rate bit did not toggle");

  p_half_on_q_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && (bits_o.half != $past(bits_o.half))) |-> $fell(bits_o.q))
    else $error("half-rate bit moved without a main falling edge");

  p_inv_after_q_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $fell(bits_o.q)) |-> bits_o.inv)
    else $error("inverted bit low after main fell");

  p_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (cnt_q == '0 && !seen_q))
    else $error("divider not cleared by reset");

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (cnt_q == '0))
    else $error("divider advanced before release");
endmodule

// File: rtl/clkdist_top.sv
module clkdist_top
  import clkdist_pkg::*;
#(
  parameter int unsigned NUM_Q       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             rst_ni,
  input  logic             vco_clk_i,
  input  logic             ref0_clk_i,
  input  logic             ref1_clk_i,
  input  logic             ref_sel_i,
  input  logic             pll_en_i,
  input  logic             div1_i,
  input  logic             loop_lock_i,
  output logic             pd_ref_o,
  output logic             dbl_o,
  output logic             dbl_oe_o,
  output logic [NUM_Q-1:0] q_o,
  output logic [NUM_Q-1:0] q_oe_o,
  output logic             inv_o,
  output logic             inv_oe_o,
  output logic             half_o,
  output logic             half_oe_o,
  output logic             lock_o
);
  logic      src_clk;
  logic      run;
  div_bits_t bits;

  clkdist_src_sel u_src_sel (
    .ref0_clk_i (ref0_clk_i),
    .ref1_clk_i (ref1_clk_i),
    .ref_sel_i  (ref_sel_i),
    .vco_clk_i  (vco_clk_i),
    .pll_en_i   (pll_en_i),
    .ref_clk_o  (pd_ref_o),
    .src_clk_o  (src_clk)
  );

  clkdist_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (src_clk),
    .rst_ni (rst_ni),
    .run_o  (run)
  );

  clkdist_div u_div (
    .clk_i  (src_clk),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div1_i (div1_i),
    .bits_o (bits)
  );

  // divide-by-one: double-rate output is the source itself, inverted
  assign dbl_o     = rst_ni & (div1_i ? ~src_clk : bits.dbl);
  assign dbl_oe_o  = rst_ni;
  assign inv_o     = bits.inv;
  assign inv_oe_o  = rst_ni;
  assign half_o    = bits.half;
  assign half_oe_o = rst_ni;

  generate
    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
      assign q_o[i]    = bits.q;
      assign q_oe_o[i] = rst_ni;
    end
  endgenerate

  assign lock_o = pll_en_i & loop_lock_i;

  p_lock_gate_r8: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    !pll_en_i |-> !lock_o)
    else $error("lock reported in bypass mode");
endmodule

// File: tb/clkdist_top_tb_top.sv
module clkdist_top_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int NUM_Q       = 5;
  localparam int SYNC_STAGES = 2;
  localparam int WD_CYCLES   = 200000;
  localparam int NVEC        = 6;

  // {pll_en, div1, ref_sel, edges}
  localparam logic [10:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 8'd20},
    {1'b1, 1'b1, 1'b0, 8'd12},
    {1'b0, 1'b0, 1'b0, 8'd20},
    {1'b0, 1'b1, 1'b1, 8'd12},
    {1'b0, 1'b0, 1'b1, 8'd18},
    {1'b1, 1'b0, 1'b1, 8'd10}
  };

  logic clk;
  logic rst_ni, ref0, ref1, ref_sel, pll_en, div1, loop_lock;
  logic pd_ref_o, dbl_o, dbl_oe_o, inv_o, inv_oe_o, half_o, half_oe_o, lock_o;
  logic [NUM_Q-1:0] q_o, q_oe_o;
  int n_checks, n_errs;
  bit done;

  clkdist_top #(.NUM_Q(NUM_Q), .SYNC_STAGES(SYNC_STAGES)) dut_i (
    .rst_ni      (rst_ni),
    .vco_clk_i   (clk),
    .ref0_clk_i  (ref0),
    .ref1_clk_i  (ref1),
    .ref_sel_i   (ref_sel),
    .pll_en_i    (pll_en),
    .div1_i      (div1),
    .loop_lock_i (loop_lock),
    .pd_ref_o    (pd_ref_o),
    .dbl_o       (dbl_o),
    .dbl_oe_o    (dbl_oe_o),
    .q_o         (q_o),
    .q_oe_o      (q_oe_o),
    .inv_o       (inv_o),
    .inv_oe_o    (inv_oe_o),
    .half_o      (half_o),
    .half_oe_o   (half_oe_o),
    .lock_o      (lock_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit q_of(input int c, input bit d1);
    return d1 ? c[0] : c[1];
  endfunction

  function automatic bit half_of(input int c, input bit d1);
    return d1 ? c[1] : c[2];
  endfunction

  function automatic bit seen_of(input int adv, input bit d1);
    for (int c = 0; c < adv; c++) if (q_of(c, d1)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic set_ref(input logic v);
    if (ref_sel) ref1 = v;
    else         ref0 = v;
  endtask

  task automatic check_run(input int adv, input bit src_hi);
    bit eq, eh, ed, ei;
    eq = q_of(adv, div1);
    eh = half_of(adv, div1);
    ed = div1 ? !src_hi : adv[0];
    ei = seen_of(adv, div1) & ~eq;
    chk($sformatf("%s/%s", div1 ? "R4 div-by-one" : "R3 div-by-two",
                  pll_en ? "R2 osc source" : "R2 ref source"),
        {dbl_o, q_o[0], half_o}, {ed, eq, eh});
    chk("R5 in-phase and inverted", {q_o, inv_o}, {{NUM_Q{eq}}, ei});
    chk("R7 enables on", {dbl_oe_o, q_oe_o, inv_oe_o, half_oe_o}, {(NUM_Q+3){1'b1}});
  endtask

  // one source rising edge, sampled in high and low phase
  task automatic src_edge(input bit do_chk, input int adv);
    if (pll_en) begin
      @(posedge clk);
      #(CLK_PERIOD/5);
      if (do_chk) check_run(adv, 1'b1);
      #(2*CLK_PERIOD/5);
      if (do_chk) check_run(adv, 1'b0);
    end else begin
      set_ref(1'b1);
      #(CLK_PERIOD/5);
      if (do_chk) check_run(adv, 1'b1);
      #(CLK_PERIOD/5);
      set_ref(1'b0);
      #(CLK_PERIOD/5);
      if (do_chk) check_run(adv, 1'b0);
      #(CLK_PERIOD/5);
    end
  endtask

  task automatic apply_reset(input bit p, input bit d1, input bit s);
    @(posedge clk);
    #(7*CLK_PERIOD/10);
    rst_ni = 1'b0;
    pll_en = p; div1 = d1; ref_sel = s;
    ref0 = 1'b0; ref1 = 1'b0;
    #(CLK_PERIOD/10);
    chk("R6 disabled and cleared",
        {dbl_oe_o, q_oe_o, inv_oe_o, half_oe_o, dbl_o, q_o, inv_o, half_o}, '0);
    rst_ni = 1'b1;
    #(CLK_PERIOD/10);
    chk("R7 release levels", {dbl_o, q_o, inv_o, half_o}, {d1, {NUM_Q{1'b0}}, 2'b00});
  endtask

  initial begin
    #(CLK_PERIOD*WD_CYCLES);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_errs = 0; done = 1'b0;
    rst_ni = 1'b0; ref0 = 1'b0; ref1 = 1'b0; ref_sel = 1'b0;
    pll_en = 1'b1; div1 = 1'b0; loop_lock = 1'b0;

    // table walk: every mode and divide setting
    for (int v = 0; v < NVEC; v++) begin
      logic [10:0] e;
      e = VECS[v];
      apply_reset(e[10], e[9], e[8]);
      for (int n = 1; n <= int'(e[7:0]); n++)
        src_edge(1'b1, (n > SYNC_STAGES) ? n - SYNC_STAGES : 0);
    end

    // R7 hold until reference pulses; R2 oscillator ignored in bypass
    apply_reset(1'b0, 1'b0, 1'b0);
    repeat (10) @(posedge clk);
    #1;
    chk("R2 vco ignored in bypass", {dbl_o, q_o, inv_o, half_o}, '0);
    for (int n = 1; n <= SYNC_STAGES; n++) src_edge(1'b0, 0);
    chk("R7 held before first advance", {dbl_o, q_o, inv_o, half_o}, '0);
    src_edge(1'b0, 0);
    chk("R7 first advance edge", {dbl_o, q_o, inv_o, half_o}, {1'b1, {(NUM_Q+2){1'b0}}});

    // R7 divide-by-one release follows inverse of reference
    apply_reset(1'b0, 1'b1, 1'b0);
    ref0 = 1'b1;
    #1;
    chk("R7 dbl inverse of ref high", dbl_o, 1'b0);
    ref0 = 1'b0;
    #1;
    chk("R7 dbl inverse of ref low", dbl_o, 1'b1);

    // R1 unselected reference ignored
    apply_reset(1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 5; n++) begin
      ref1 = 1'b1; #2;
      chk("R1 pd_ref ignores ref1", pd_ref_o, 1'b0);
      ref1 = 1'b0; #2;
    end
    chk("R1 unselected ref no effect", {dbl_o, q_o, inv_o, half_o}, '0);
    ref0 = 1'b1; #1;
    chk("R1 pd_ref follows ref0", pd_ref_o, 1'b1);
    ref0 = 1'b0;

    apply_reset(1'b1, 1'b0, 1'b1);
    ref1 = 1'b1; ref0 = 1'b0; #1;
    chk("R1 pd_ref follows ref1", pd_ref_o, 1'b1);
    ref1 = 1'b0; ref0 = 1'b1; #1;
    chk("R1 pd_ref ignores ref0", pd_ref_o, 1'b0);
    ref0 = 1'b0;

    // R6 asynchronous disable mid-run
    apply_reset(1'b1, 1'b0, 1'b0);
    for (int n = 1; n <= 11; n++) src_edge(1'b0, 0);
    chk("R6 running before drop", {dbl_o, inv_o}, 2'b11);
    @(posedge clk);
    #(CLK_PERIOD/5);
    rst_ni = 1'b0;
    #1;
    chk("R6 immediate disable",
        {dbl_oe_o, q_oe_o, inv_oe_o, half_oe_o, dbl_o, q_o, inv_o, half_o}, '0);
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/5);
    chk("R6 stays disabled",
        {dbl_oe_o, q_oe_o, inv_oe_o, half_oe_o, dbl_o, q_o, inv_o, half_o}, '0);

    // R8 lock gating
    pll_en = 1'b1; loop_lock = 1'b1; #1;
    chk("R8 lock passes", lock_o, 1'b1);
    loop_lock = 1'b0; #1;
    chk("R8 lock follows flag", lock_o, 1'b0);
    pll_en = 1'b0; loop_lock = 1'b1; #1;
    chk("R8 lock gated in bypass", lock_o, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule